// File: doc/BRIEF.md
# Parallel-Jam Serial-Out Shift Register

This block is a chain of storage stages with two ways to change its contents. While the mode input is low, the chain acts as a plain serial shifter. On every rising clock edge, the serial input enters the first stage and each later stage takes the old value of the stage before it. While the mode input is high, every stage is forced at once to its own parallel input bit. This happens without waiting for a clock edge. The clock and the serial input then have no effect.

A typical use is to capture a parallel word with a pulse on the mode input and then clock it out one bit per edge from the last stage. The three stages at the end of the chain are the only ones brought out. The first of these appears two clocks ahead of the last stage, and the second appears one clock ahead of it.

The immediate load is built from a separate asynchronous set and asynchronous clear on each stage flop. Set is active when mode is high and the parallel bit is 1. Clear is active when mode is high and the parallel bit is 0. This keeps the block within ordinary synthesizable flop types.

Top module: `jamreg_par_shift`

## Requirements
- R1: With `load_mode` low, each rising edge of `clk` moves `ser_in` into stage 1 and moves the old value of stage k into stage k+1, for k from 1 to 7.
- R2: With `load_mode` high, stage k equals `par_in[k-1]` at once, without any clock edge. Bit 0 feeds stage 1 and bit 7 feeds stage 8. A change of `par_in` during the load reaches the stages at once.
- R3: With `load_mode` high, rising edges of `clk` and changes of `ser_in` leave the stages unchanged from the parallel word.
- R4: With `load_mode` low, the stages hold their values when there is no rising clock edge, including across a falling edge.
- R5: When `load_mode` falls from 1 to 0, the stages keep the last loaded word until the next rising clock edge.
- R6: `tap6`, `tap7` and `tap8` show stages 6, 7 and 8, so in shift mode `tap8` takes the old `tap7` and `tap7` takes the old `tap6` on each rising edge.
- R7: After a load of word W and then k shift edges, with k from 0 to 7, `tap8` equals bit 7-k of W.
- R8: With `load_mode` low, `par_in` has no effect on the stages.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; the rising edge advances the chain |
| ser_in | input | 1 | Serial data taken into stage 1 |
| load_mode | input | 1 | 1 forces all stages to `par_in` immediately; 0 selects shifting |
| par_in | input | 8 | Parallel word; bit k-1 feeds stage k |
| tap6 | output | 1 | Value of stage 6 |
| tap7 | output | 1 | Value of stage 7 |
| tap8 | output | 1 | Value of stage 8 |

## Verification
The clocked properties sample the stages on rising edges. They take for granted that `load_mode`, `par_in` and `ser_in` never change close to a rising clock edge. They also assume that every high pulse of `load_mode` covers at least one rising edge, so that a load cannot come and go unseen between two samples. The stimulus changes inputs only two or more time units away from either clock edge. Each load starts in the high or the low clock phase, chosen at random. The load mode is then held through a rising edge, and it is released in either the high or the low phase.

// File: rtl/jamreg_pkg.sv
package jamreg_pkg;
  localparam int unsigned DEF_STAGES = 8;
  localparam int unsigned TAP_COUNT  = 3;

  typedef enum logic {
    MODE_SHIFT = 1'b0,
    MODE_JAM   = 1'b1
  } jam_mode_e;
endpackage

// File: rtl/jamreg_cell.sv
module jamreg_cell (
  input  logic clk,
  input  logic set_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o
);
  logic q_r;

  always_ff @(posedge clk or posedge set_i or posedge clr_i) begin
    if (clr_i) begin
      q_r <= 1'b0;
    end else if (set_i) begin
      q_r <= 1'b1;
    end else begin
      q_r <= d_i;
    end
  end

  assign q_o = q_r;

  // R2
  cell_set_chk: assert property (@(posedge clk) set_i |-> q_r);
  // R2
  cell_clr_chk: assert property (@(posedge clk) clr_i |-> !q_r);
endmodule

// File: rtl/jamreg_ctrl.sv
module jamreg_ctrl #(
  parameter int unsigned STAGES = jamreg_pkg::DEF_STAGES
) (
  input  logic              mode_i,
  input  logic [STAGES-1:0] par_i,
  output logic [STAGES-1:0] set_o,
  output logic [STAGES-1:0] clr_o
);
  import jamreg_pkg::*;

  jam_mode_e mode_q;
  logic      jam_on;

  always_comb begin
    mode_q = jam_mode_e'(mode_i);
    jam_on = (mode_q == MODE_JAM);
  end

  always_comb begin
    set_o = {STAGES{jam_on}} & par_i;
    clr_o = {STAGES{jam_on}} & ~par_i;
  end
endmodule

// File: rtl/jamreg_chain.sv
module jamreg_chain #(
  parameter int unsigned STAGES = jamreg_pkg::DEF_STAGES
) (
  input  logic              clk,
  input  logic              ser_i,
  input  logic              jam_i,
  input  logic [STAGES-1:0] par_i,
  input  logic [STAGES-1:0] set_i,
  input  logic [STAGES-1:0] clr_i,
  output logic [STAGES-1:0] stage_o
);
  logic [STAGES-1:0] stage_d;
  logic [STAGES-1:0] stage_q;

  always_comb begin
    stage_d = {stage_q[STAGES-2:0], ser_i};
  end

  for (genvar k = 0; k < STAGES; k++) begin : g_cell
    jamreg_cell u_cell (
      .clk   (clk),
      .set_i (set_i[k]),
      .clr_i (clr_i[k]),
      .d_i   (stage_d[k]),
      .q_o   (stage_q[k])
    );
  end

  assign stage_o = stage_q;

  // R1
  stage_adv_chk: assert property (@(posedge clk)
    (!jam_i && !$past(jam_i)) |->
      (stage_q == {$past(stage_q[STAGES-2:0]), $past(ser_i)}));

  // R3
  jam_track_chk: assert property (@(posedge clk) jam_i |-> (stage_q == par_i));
endmodule

// File: rtl/jamreg_par_shift.sv
module jamreg_par_shift #(
  parameter int unsigned STAGES = jamreg_pkg::DEF_STAGES
) (
  input  logic              clk,
  input  logic              ser_in,
  input  logic              load_mode,
  input  logic [STAGES-1:0] par_in,
  output logic              tap6,
  output logic              tap7,
  output logic              tap8
);
  localparam int unsigned LAST = STAGES - 1;
  localparam int unsigned TAPS = jamreg_pkg::TAP_COUNT;

  logic [STAGES-1:0] set_v;
  logic [STAGES-1:0] clr_v;
  logic [STAGES-1:0] stages;
  logic [TAPS-1:0]   tap_v;

  jamreg_ctrl #(.STAGES(STAGES)) u_ctrl (
    .mode_i (load_mode),
    .par_i  (par_in),
    .set_o  (set_v),
    .clr_o  (clr_v)
  );

  jamreg_chain #(.STAGES(STAGES)) u_chain (
    .clk     (clk),
    .ser_i   (ser_in),
    .jam_i   (load_mode),
    .par_i   (par_in),
    .set_i   (set_v),
    .clr_i   (clr_v),
    .stage_o (stages)
  );

  always_comb begin
    tap_v = stages[LAST -: TAPS];
  end

  assign tap6 = tap_v[0];
  assign tap7 = tap_v[1];
  assign tap8 = tap_v[2];

  // R6
  tap_adv_chk: assert property (@(posedge clk)
    (!load_mode && !$past(load_mode)) |->
      (tap8 == $past(tap7) && tap7 == $past(tap6)));
endmodule

// File: tb/jamreg_par_shift_test.sv
module jamreg_par_shift_test;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       ser_in = 1'b0;
  logic       load_mode = 1'b1;
  logic [7:0] par_in = 8'hA5;
  logic       tap6, tap7, tap8;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] m;
  bit was_high = 1'b1;

  jamreg_par_shift uut (
    .clk       (clk),
    .ser_in    (ser_in),
    .load_mode (load_mode),
    .par_in    (par_in),
    .tap6      (tap6),
    .tap7      (tap7),
    .tap8      (tap8)
  );

  always #(PERIOD/2) clk = ~clk;

  always @(posedge clk or negedge load_mode) begin
    if (!load_mode) begin
      if (was_high) m = par_in;
      else          m = {m[6:0], ser_in};
    end
    was_high = load_mode;
  end

  function automatic logic [2:0] expect_taps();
    logic [7:0] s;
    s = load_mode ? par_in : m;
    return s[7:5];
  endfunction

  task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_taps(input string tag);
    check(tag, {tap8, tap7, tap6}, expect_taps());
  endtask

  task automatic do_shift(input logic s, input bit hold_chk);
    ser_in = s;
    par_in = 8'($urandom);
    @(posedge clk); #2;
    check_taps("R1 R8");
    if (hold_chk) begin
      @(negedge clk); #2;
      check_taps("R4");
    end
  endtask

  task automatic jam(input logic [7:0] w, input bit start_high, input bit rel_high);
    if (start_high) begin @(posedge clk); #2; end
    else begin @(negedge clk); #2; end
    load_mode = 1'b1;
    par_in = w;
    #1 check_taps("R2");
    @(posedge clk); #2;
    ser_in = ~ser_in;
    check_taps("R3");
    if (!rel_high) begin @(negedge clk); #2; end
    load_mode = 1'b0;
    #1 check_taps("R5");
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    #3;
    check("R2 reset", {tap8, tap7, tap6}, 3'b101);
    check("R6", {tap8, tap7, tap6}, {par_in[7], par_in[6], par_in[5]});

    @(negedge clk); #2;
    par_in = 8'h3C;
    #1 check("R2", {tap8, tap7, tap6}, 3'b001);
    @(posedge clk); #2;
    ser_in = 1'b1;
    check("R3", {tap8, tap7, tap6}, 3'b001);

    @(negedge clk); #2;
    load_mode = 1'b0;
    #1 check("R5", {tap8, tap7, tap6}, 3'b001);
    @(negedge clk); #1;
    check("R5 hold", {tap8, tap7, tap6}, 3'b011);

    jam(8'b1011_0010, 1'b1, 1'b1);
    check("R7", {2'b00, tap8}, 3'b001);
    for (int k = 1; k < 8; k++) begin
      ser_in = 1'b0;
      @(posedge clk); #2;
      check("R7", {2'b00, tap8}, {2'b00, (8'b1011_0010 >> (7 - k)) & 8'h1});
    end

    jam(8'h00, 1'b0, 1'b1);
    do_shift(1'b1, 1'b1);
    jam(8'hFF, 1'b1, 1'b0);
    do_shift(1'b0, 1'b1);

    for (int i = 0; i < 400; i++) begin
      if ($urandom_range(0, 15) == 0)
        jam(8'($urandom), 1'($urandom), 1'($urandom));
      do_shift(1'($urandom), ($urandom_range(0, 3) == 0));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule